// File: doc/BRIEF.md
# Serial Audio Transmit Port

This block turns a stream of parallel PCM words into a serial audio bit stream. It drives its own bit clock and a matching frame-sync line, and it runs in master mode from a single-cycle enable tick. Two ticks make one bit period. On the first tick the bit clock falls to its drive level and new data and sync values go out. On the second tick it rises to the sampling level. One frame engine covers four framing conventions. It does this by combining three selectors: a sync that lasts a word or a single bit, an active-high or active-low sync, and a sync that starts one bit early or on time. Polarity inversion of the bit clock and of the sync is applied on top of the chosen format.

A frame holds `cfg_slots_m1 + 1` time slots, and each slot is one word long. Words are taken MSB first from a valid/ready input. Any slot whose mask bit is set stays silent. If the source has no word at the start of an active slot, the block sends zeros and raises a sticky underrun flag. All configuration is captured only while the port is disabled.

Top module: `sat_tx`

## Requirements
- R1: After reset with `en` low, `sdata`, `bclk`, `in_ready` and `urun` are 0 and `fsync` is 1, which is the idle level of the reset format code 0.
- R2: The word length code selects 16 (code 0), 20 (code 1) or 24 bits (codes 2 and 3). Only the low word-length bits of `in_data` are sent, MSB first, one bit per bit period.
- R3: Format code 0: the sync is active low for one word length and goes active one bit period before the first data bit of slot 0.
- R4: Format code 1: the sync is active high for exactly the bit periods of slot 0.
- R5: Format code 2: the sync is a one-bit-period high pulse during the last bit period of the previous frame.
- R6: Format code 3: the sync is a one-bit-period high pulse aligned with the first data bit of slot 0.
- R7: Data and sync change only when the bit clock moves to its drive level. Without inversion the drive level is low, so the receiver samples on the rising edge. `cfg_inv_bclk` inverts the bit clock and `cfg_inv_fs` inverts the sync.
- R8: A frame is `(cfg_slots_m1+1)` × word-length bit periods long. The first bit period after enable is a lead-in that acts as the final bit position of a frame and carries zero data.
- R9: Bit i of `cfg_mask` set means slot i sends zeros, does not raise `in_ready` and consumes no word.
- R10: When an active slot starts with `in_valid` low, the slot sends zeros and `urun` is set. `urun` stays set until a cycle with `urun_clr` high. When setting and clearing fall in the same cycle, the set wins.
- R11: Configuration inputs are captured only while `en` is low. Changes made while `en` is high have no effect until the port is disabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Port enable; configuration is captured while low |
| bclk_tick | input | 1 | Half-bit-period enable tick |
| cfg_fmt | input | 2 | Frame format code (0..3) |
| cfg_inv_bclk | input | 1 | Invert the bit clock |
| cfg_inv_fs | input | 1 | Invert the frame sync |
| cfg_wl | input | 2 | Word length code |
| cfg_slots_m1 | input | SLOT_W | Slots per frame minus one |
| cfg_mask | input | MAX_SLOTS | Per-slot disable bits |
| urun_clr | input | 1 | Write-one clear of the underrun flag |
| in_valid | input | 1 | Input word available |
| in_data | input | DATA_W | Input word, right-aligned |
| in_ready | output | 1 | Word accepted at this edge if valid |
| sdata | output | 1 | Serial data |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| urun | output | 1 | Sticky underrun flag |

## Verification
The underrun set and its write-one clear can fall in the same cycle. The bench provokes this by starving the port and waiting for the cycle in which `in_ready` shows a slot is about to start. It raises `urun_clr` for exactly that edge and then requires the flag to still be set. A second pair to watch is a configuration change and a running frame: the bench rewrites every configuration input mid-frame. It then requires the captured bit stream to keep the old format, and requires the new idle sync level to appear only after the port is disabled.

// File: rtl/sat_pkg.sv
package sat_pkg;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_DSPA = 2'd2,
    FMT_DSPB = 2'd3
  } fmt_e;

  typedef struct packed {
    logic word_len;  // sync spans a word instead of one bit
    logic act_low;   // sync asserted low by default
    logic early;     // sync leads the first data bit by one bit period
  } sync_sel_t;

  function automatic sync_sel_t sync_sel(input logic [1:0] f);
    sync_sel_t s;
    case (f)
      FMT_I2S:  s = '{word_len: 1'b1, act_low: 1'b1, early: 1'b1};
      FMT_LJ:   s = '{word_len: 1'b1, act_low: 1'b0, early: 1'b0};
      FMT_DSPA: s = '{word_len: 1'b0, act_low: 1'b0, early: 1'b1};
      default:  s = '{word_len: 1'b0, act_low: 1'b0, early: 1'b0};
    endcase
    return s;
  endfunction

  function automatic int unsigned word_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 20;
      default: return 24;
    endcase
  endfunction

  // sync activity for a bit position, before polarity is applied
  function automatic logic sync_active(input sync_sel_t s, input logic in_slot0,
                                       input logic first_bit, input logic last_bit,
                                       input logic frame_last, input logic lead);
    if (s.early)
      return s.word_len ? ((in_slot0 && !last_bit && !lead) || frame_last) : frame_last;
    else
      return s.word_len ? (in_slot0 && !lead) : (in_slot0 && first_bit && !lead);
  endfunction

endpackage

// File: rtl/sat_cfg_hold.sv
module sat_cfg_hold #(
  parameter int MAX_SLOTS = 8,
  parameter int SLOT_W    = $clog2(MAX_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [1:0]           fmt_i,
  input  logic                 inv_bclk_i,
  input  logic                 inv_fs_i,
  input  logic [1:0]           wl_i,
  input  logic [SLOT_W-1:0]    slots_m1_i,
  input  logic [MAX_SLOTS-1:0] mask_i,
  output logic [1:0]           fmt_q,
  output logic                 inv_bclk_q,
  output logic                 inv_fs_q,
  output logic [1:0]           wl_q,
  output logic [SLOT_W-1:0]    slots_m1_q,
  output logic [MAX_SLOTS-1:0] mask_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q      <= '0;
      inv_bclk_q <= 1'b0;
      inv_fs_q   <= 1'b0;
      wl_q       <= '0;
      slots_m1_q <= '0;
      mask_q     <= '0;
    end else if (!en) begin
      fmt_q      <= fmt_i;
      inv_bclk_q <= inv_bclk_i;
      inv_fs_q   <= inv_fs_i;
      wl_q       <= wl_i;
      slots_m1_q <= slots_m1_i;
      mask_q     <= mask_i;
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> $stable({fmt_q, inv_bclk_q, inv_fs_q, wl_q, slots_m1_q, mask_q})); // R11

endmodule

// File: rtl/sat_frame_ctr.sv
module sat_frame_ctr #(
  parameter int DATA_W    = 24,
  parameter int MAX_SLOTS = 8,
  parameter int SLOT_W    = $clog2(MAX_SLOTS),
  parameter int BIT_W     = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic [1:0]        wl_code,
  input  logic [SLOT_W-1:0] slots_m1,
  output logic              drive_ev,
  output logic              samp_ev,
  output logic              slot_start_ev,
  output logic [SLOT_W-1:0] nxt_slot,
  output logic              nxt_lead,
  output logic              nxt_first,
  output logic              nxt_lastbit,
  output logic              nxt_frame_last
);
  import sat_pkg::*;

  logic              ph_q, primed_q;
  logic [SLOT_W-1:0] slot_q;
  logic [BIT_W-1:0]  bit_q, nxt_bit, wl_m1;

  assign wl_m1         = BIT_W'(word_bits(wl_code) - 1);
  assign drive_ev      = en && tick && !ph_q;
  assign samp_ev       = en && tick && ph_q;
  assign slot_start_ev = drive_ev && primed_q && (bit_q == '0);

  // position presented at the coming drive edge; bit index counts down
  always_comb begin
    nxt_lead = 1'b0;
    nxt_slot = slot_q;
    nxt_bit  = bit_q - 1'b1;
    if (!primed_q) begin
      nxt_lead = 1'b1;
      nxt_slot = slots_m1;
      nxt_bit  = '0;
    end else if (bit_q == '0) begin
      nxt_bit  = wl_m1;
      nxt_slot = (slot_q == slots_m1) ? '0 : slot_q + 1'b1;
    end
  end

  assign nxt_first      = (nxt_bit == wl_m1);
  assign nxt_lastbit    = (nxt_bit == '0);
  assign nxt_frame_last = nxt_lastbit && (nxt_slot == slots_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= 1'b0; primed_q <= 1'b0; slot_q <= '0; bit_q <= '0;
    end else if (!en) begin
      ph_q <= 1'b0; primed_q <= 1'b0; slot_q <= '0; bit_q <= '0;
    end else begin
      if (tick) ph_q <= ~ph_q;
      if (drive_ev) begin
        primed_q <= 1'b1;
        slot_q   <= nxt_slot;
        bit_q    <= nxt_bit;
      end
    end
  end

  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |-> (slot_q <= slots_m1)); // R8
  AST_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |-> (bit_q <= wl_m1)); // R2

endmodule

// File: rtl/sat_shifter.sv
module sat_shifter #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              drive_ev,
  input  logic              slot_start_ev,
  input  logic              slot_masked,
  input  logic [1:0]        wl_code,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              urun_clr,
  output logic              in_ready,
  output logic              sdata,
  output logic              urun
);
  import sat_pkg::*;

  logic [DATA_W-1:0] sh_q, aligned;
  logic              take, starve;

  assign in_ready = slot_start_ev && !slot_masked;
  assign take     = in_ready && in_valid;
  assign starve   = in_ready && !in_valid;
  assign aligned  = in_data << (DATA_W - int'(word_bits(wl_code)));
  assign sdata    = sh_q[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      urun <= 1'b0;
    end else begin
      if (!en)                sh_q <= '0;
      else if (slot_start_ev) sh_q <= take ? aligned : '0;
      else if (drive_ev)      sh_q <= sh_q << 1;
      if (starve)             urun <= 1'b1;
      else if (urun_clr)      urun <= 1'b0;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sdata); // R1
  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start_ev && slot_masked) |=> !sdata); // R9
  AST_URUN_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    starve |=> urun); // R10
  AST_URUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (urun && !urun_clr) |=> urun); // R10

endmodule

// File: rtl/sat_tx.sv
module sat_tx #(
  parameter int DATA_W    = 24,
  parameter int MAX_SLOTS = 8,
  parameter int SLOT_W    = $clog2(MAX_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 bclk_tick,
  input  logic [1:0]           cfg_fmt,
  input  logic                 cfg_inv_bclk,
  input  logic                 cfg_inv_fs,
  input  logic [1:0]           cfg_wl,
  input  logic [SLOT_W-1:0]    cfg_slots_m1,
  input  logic [MAX_SLOTS-1:0] cfg_mask,
  input  logic                 urun_clr,
  input  logic                 in_valid,
  input  logic [DATA_W-1:0]    in_data,
  output logic                 in_ready,
  output logic                 sdata,
  output logic                 bclk,
  output logic                 fsync,
  output logic                 urun
);
  import sat_pkg::*;

  logic [1:0]           fmt_q, wl_q;
  logic                 inv_bclk_q, inv_fs_q;
  logic [SLOT_W-1:0]    slots_m1_q;
  logic [MAX_SLOTS-1:0] mask_q;
  logic                 drive_ev, samp_ev, slot_start_ev;
  logic [SLOT_W-1:0]    nxt_slot;
  logic                 nxt_lead, nxt_first, nxt_lastbit, nxt_frame_last;
  logic                 fs_q, bclk_q, fs_act;
  sync_sel_t            sel;

  sat_cfg_hold #(.MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u_cfg (
    .clk, .rst_n, .en,
    .fmt_i(cfg_fmt), .inv_bclk_i(cfg_inv_bclk), .inv_fs_i(cfg_inv_fs),
    .wl_i(cfg_wl), .slots_m1_i(cfg_slots_m1), .mask_i(cfg_mask),
    .fmt_q, .inv_bclk_q, .inv_fs_q, .wl_q, .slots_m1_q, .mask_q
  );

  sat_frame_ctr #(.DATA_W(DATA_W), .MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u_frame (
    .clk, .rst_n, .en, .tick(bclk_tick), .wl_code(wl_q), .slots_m1(slots_m1_q),
    .drive_ev, .samp_ev, .slot_start_ev, .nxt_slot, .nxt_lead,
    .nxt_first, .nxt_lastbit, .nxt_frame_last
  );

  sat_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk, .rst_n, .en, .drive_ev, .slot_start_ev,
    .slot_masked(mask_q[nxt_slot]), .wl_code(wl_q),
    .in_valid, .in_data, .urun_clr, .in_ready, .sdata, .urun
  );

  assign sel    = sync_sel(fmt_q);
  assign fs_act = sync_active(sel, nxt_slot == '0, nxt_first, nxt_lastbit,
                              nxt_frame_last, nxt_lead);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= 1'b1;
      bclk_q <= 1'b0;
    end else if (!en) begin
      fs_q   <= sel.act_low ^ inv_fs_q;
      bclk_q <= 1'b0;
    end else if (drive_ev) begin
      fs_q   <= fs_act ^ sel.act_low ^ inv_fs_q;
      bclk_q <= 1'b0;
    end else if (samp_ev) begin
      bclk_q <= 1'b1;
    end
  end

  assign fsync = fs_q;
  assign bclk  = bclk_q ^ inv_bclk_q;

  AST_DATA_ON_DRIVE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (sdata != $past(sdata))) |-> $past(drive_ev)); // R7
  AST_SYNC_ON_DRIVE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(drive_ev)) |-> $stable(fsync)); // R7
  AST_BCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$past(en)) |-> (bclk == inv_bclk_q)); // R1

endmodule

// File: tb/sim_sat_tx.sv
module sim_sat_tx;

  localparam int DATA_W = 24;
  localparam int MAX_SLOTS = 8;
  localparam int SLOT_W = 3;

  typedef struct packed {
    logic [1:0] fmt;
    logic [1:0] wl;
    logic [2:0] sm1;
    logic [7:0] mask;
    logic       ib;
    logic       ifs;
    logic       poke;
  } vec_t;

  // fmt, wl, slots-1, mask, inv_bclk, inv_fs, poke
  localparam vec_t VECS [0:7] = '{
    '{2'd0, 2'd0, 3'd1, 8'h00, 1'b0, 1'b0, 1'b0},  // R3 R2
    '{2'd1, 2'd1, 3'd1, 8'h00, 1'b0, 1'b0, 1'b0},  // R4
    '{2'd2, 2'd2, 3'd3, 8'h04, 1'b0, 1'b0, 1'b0},  // R5 R9
    '{2'd3, 2'd0, 3'd2, 8'h01, 1'b0, 1'b0, 1'b0},  // R6 R9
    '{2'd0, 2'd2, 3'd1, 8'h00, 1'b1, 1'b1, 1'b0},  // R7
    '{2'd3, 2'd1, 3'd7, 8'hA5, 1'b0, 1'b1, 1'b0},  // R6 R8 R9
    '{2'd1, 2'd3, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0},  // R4 R2
    '{2'd0, 2'd0, 3'd1, 8'h00, 1'b0, 1'b0, 1'b1}   // R11
  };

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, tick = 1'b0;
  logic [1:0] cfg_fmt = '0, cfg_wl = '0;
  logic cfg_inv_bclk = 1'b0, cfg_inv_fs = 1'b0, urun_clr = 1'b0;
  logic [SLOT_W-1:0] cfg_slots_m1 = '0;
  logic [MAX_SLOTS-1:0] cfg_mask = '0;
  logic in_valid, in_ready, sdata, bclk, fsync, urun;
  logic [DATA_W-1:0] in_data;

  logic src_on = 1'b0, src_clear = 1'b1, cap_clear = 1'b1;
  int src_idx;
  logic [1:0] cur_fmt = '0;
  logic cur_ib = 1'b0, cur_ifs = 1'b0;
  logic cap_d [0:511];
  logic cap_f [0:511];
  int cap_n, viol;
  logic prev_bn, prev_sd;
  wire bn = bclk ^ cur_ib;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  function automatic logic [23:0] word_of(input int i);
    logic [31:0] t;
    t = (i + 1) * 32'h9E3779B1;
    return t[27:4];
  endfunction

  function automatic int wbits(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 20 : 24;
  endfunction

  function automatic string fmt_req(input logic [1:0] f);
    case (f)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  sat_tx #(.DATA_W(DATA_W), .MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u0 (
    .clk, .rst_n, .en, .bclk_tick(tick), .cfg_fmt, .cfg_inv_bclk, .cfg_inv_fs,
    .cfg_wl, .cfg_slots_m1, .cfg_mask, .urun_clr, .in_valid, .in_data,
    .in_ready, .sdata, .bclk, .fsync, .urun
  );

  assign in_valid = src_on && (src_idx < 64);
  assign in_data  = word_of(src_idx);

  always @(posedge clk) tick <= rst_n ? ~tick : 1'b0;

  always @(posedge clk)
    if (src_clear) src_idx <= 0;
    else if (in_valid && in_ready) src_idx <= src_idx + 1;

  always @(negedge clk) begin
    if (cap_clear) begin
      cap_n <= 0; viol <= 0; prev_bn <= 1'b0; prev_sd <= 1'b0;
    end else if (en) begin
      if (bn && !prev_bn && cap_n < 512) begin
        cap_d[cap_n] <= sdata;
        cap_f[cap_n] <= fsync ^ cur_ifs ^ (cur_fmt == 2'd0);
        cap_n <= cap_n + 1;
      end
      if ((sdata != prev_sd) && bn) viol <= viol + 1;
      prev_bn <= bn;
      prev_sd <= sdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input bit empty);
    int L;
    L = 1 + 2 * (v.sm1 + 1) * wbits(v.wl);
    @(negedge clk);
    en = 1'b0;
    cfg_fmt = v.fmt; cfg_wl = v.wl; cfg_slots_m1 = v.sm1; cfg_mask = v.mask;
    cfg_inv_bclk = v.ib; cfg_inv_fs = v.ifs;
    cur_fmt = v.fmt; cur_ib = v.ib; cur_ifs = v.ifs;
    src_on = !empty; src_clear = 1'b1; cap_clear = 1'b1;
    repeat (3) @(negedge clk);
    src_clear = 1'b0; cap_clear = 1'b0;
    en = 1'b1;
    while (cap_n < L && !done) begin
      @(negedge clk);
      if (v.poke && cap_n == 20) begin
        cfg_fmt = 2'd1; cfg_wl = 2'd2; cfg_slots_m1 = 3'd5; cfg_mask = 8'hFF;
        cfg_inv_bclk = 1'b1; cfg_inv_fs = 1'b0;
      end
    end
    en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_vec(input vec_t v, input bit empty, input string tag);
    int W, S, N, L, widx, bad_d, bad_f;
    logic [23:0] cw;
    W = wbits(v.wl); S = v.sm1 + 1; N = S * W; L = 1 + 2 * N;
    widx = 0; bad_d = 0; bad_f = 0; cw = '0;
    for (int k = 0; k < L; k++) begin
      int p, sl, b;
      bit last, first0, in0, msk;
      logic ed, ef;
      if (k == 0) begin
        ed = 1'b0; last = 1; in0 = 0; first0 = 0; b = W - 1;
      end else begin
        p = (k - 1) % N; sl = p / W; b = p % W;
        last = (sl == S - 1) && (b == W - 1);
        in0 = (sl == 0); first0 = in0 && (b == 0);
        msk = v.mask[sl];
        if (b == 0 && !msk) begin cw = word_of(widx); widx++; end
        ed = (msk || empty) ? 1'b0 : cw[W - 1 - b];
      end
      case (v.fmt)
        2'd0: ef = last || (in0 && b < W - 1);
        2'd1: ef = in0;
        2'd2: ef = last;
        default: ef = first0;
      endcase
      if (cap_d[k] !== ed) bad_d++;
      if (cap_f[k] !== ef) bad_f++;
    end
    chk(bad_d == 0, {tag, " R2 R9"}, "mismatched data bits", bad_d, 0);
    chk(bad_f == 0, {tag, " ", fmt_req(v.fmt), " R8"}, "mismatched sync bits", bad_f, 0);
    chk(viol == 0, {tag, " R7"}, "data changes at sampling level", viol, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sdata == 1'b0, "R1", "sdata", int'(sdata), 0);
    chk(bclk == 1'b0, "R1", "bclk", int'(bclk), 0);
    chk(fsync == 1'b1, "R1", "fsync", int'(fsync), 1);
    chk(in_ready == 1'b0, "R1", "in_ready", int'(in_ready), 0);
    chk(urun == 1'b0, "R1", "urun", int'(urun), 0);

    for (int i = 0; i < 8; i++) begin
      run_vec(VECS[i], 1'b0);
      check_vec(VECS[i], 1'b0, (i == 7) ? "R11" : "vec");
      chk(urun == 1'b0, "R10", "urun with full source", int'(urun), 0);
    end
    // R11: the configuration written while enabled takes hold after disable
    repeat (2) @(negedge clk);
    chk(fsync == 1'b0, "R11", "idle sync after late config", int'(fsync), 0);
    chk(bclk == 1'b1, "R11", "idle bclk after late config", int'(bclk), 1);

    // R10 starved source
    run_vec('{2'd3, 2'd0, 3'd1, 8'h00, 1'b0, 1'b0, 1'b0}, 1'b1);
    check_vec('{2'd3, 2'd0, 3'd1, 8'h00, 1'b0, 1'b0, 1'b0}, 1'b1, "R10");
    chk(urun == 1'b1, "R10", "urun after starvation", int'(urun), 1);
    repeat (4) @(negedge clk);
    chk(urun == 1'b1, "R10", "urun sticky", int'(urun), 1);
    urun_clr = 1'b1;
    @(negedge clk);
    urun_clr = 1'b0;
    chk(urun == 1'b0, "R10", "urun after clear", int'(urun), 0);

    // R10 set and clear in the same cycle: set wins
    src_on = 1'b0;
    en = 1'b1;
    for (int g = 0; g < 400 && !in_ready; g++) @(negedge clk);
    chk(urun == 1'b0, "R10", "urun before first slot", int'(urun), 0);
    urun_clr = 1'b1;
    @(negedge clk);
    urun_clr = 1'b0;
    chk(urun == 1'b1, "R10", "set beats clear", int'(urun), 1);
    en = 1'b0;
    repeat (2) @(negedge clk);
    urun_clr = 1'b1;
    @(negedge clk);
    urun_clr = 1'b0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule